// File: doc/BRIEF.md
# Serial Bus Pattern Trigger

This block watches the bits on a serial bus, either a four-wire SPI link or a two-wire I2C link, and emits a trigger pulse when the most recent 32 received bits match a programmable four-byte pattern. A per-bit mask relaxes the comparison. A capture engine uses the trigger to mark the instant a given command, address or data sequence crosses the bus.

The bus pins are oversampled by the block clock. They are assumed to be already synchronised to that clock, and every bus level is assumed to be held for at least one clock cycle. Each accepted bit enters a 32-bit shift register at the slot of the newest byte and moves toward the slot of the oldest byte. The newest byte is compared against pattern byte 3 and the oldest against pattern byte 0. A pattern shorter than four bytes is therefore programmed into the high-numbered bytes, and the unused low bytes are given a full ignore mask. Configuration uses a plain write port. The bus pins are sampled and cannot be stalled, so the block has no back-pressure path.

Top module: `pm_proto_match`

## Requirements
- R1: After reset, `trig` is low, all pattern bytes are 0x00, all mask bytes are 0xFF (ignore), the SPI mode is 0 and the shift register is cleared.
- R2: A write (`cfg_we` high) takes effect from the next cycle. Address k (0 to 3) sets pattern byte k, address 4+k sets mask byte k, and address 8 sets the SPI mode from `cfg_wdata[1:0]`. Writes to addresses 9 to 15 change nothing.
- R3: Each accepted bit shifts in at bit 0 of the newest byte slot. Bits are sent MSB first, so the byte received last lines up with pattern byte 3 and the byte received four bytes earlier lines up with pattern byte 0.
- R4: For each of the 32 bits, the match term is (received XOR pattern) OR mask. A mask bit of 1 ignores that bit. The full match is the AND of all 32 terms.
- R5: `trig` is high for exactly one cycle, in the cycle after the clock edge that accepts a bit turning the full match from false to true. A bit that leaves an already-true match true raises no pulse.
- R6: In SPI mode (`i2c_sel` low), the SPI mode sets the sampling edge of `sclk`. Modes 0 and 3 sample `sdi` on a rising `sclk`. Modes 1 and 2 sample it on a falling `sclk`.
- R7: In SPI mode, `sclk` edges seen while `cs_n` is high are ignored, and the shift register keeps its content.
- R8: In I2C mode (`i2c_sel` high), `sda` is sampled on each rising `scl`. The ninth clock of every frame (the acknowledge) is not shifted in.
- R9: In I2C mode, a start condition (`sda` falling while `scl` stays high) clears the shift register and restarts the frame bit count.
- R10: A pattern of one or two bytes, placed in the high-numbered bytes with the low bytes at mask 0xFF, triggers as soon as that many bytes have been received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; oversamples the bus pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| i2c_sel | input | 1 | 1 selects I2C bit qualification, 0 selects SPI |
| sclk | input | 1 | SPI serial clock |
| sdi | input | 1 | SPI data line being watched |
| cs_n | input | 1 | SPI chip select, active low |
| scl | input | 1 | I2C clock |
| sda | input | 1 | I2C data |
| trig | output | 1 | One-cycle pattern-match pulse |

## Verification
A bus edge presented before a clock edge is accepted at that clock edge. The shift register changes there, and `trig` is registered at the same edge, so the pulse is due exactly one cycle after the sampling edge is driven and lasts one cycle. The bench drives the pins just after a rising clock edge. It keeps a model of the shift register, and after every accepted bit it posts the expected trigger value for the one falling-edge sample that follows the next rising edge. Every falling edge compares `trig` against the posted value, so a pulse that comes early, late, doubled or spurious is caught in the cycle where it appears.

// File: rtl/pm_pkg.sv
`timescale 1ns/1ps
package pm_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SPI_M0 = 2'd0,
    SPI_M1 = 2'd1,
    SPI_M2 = 2'd2,
    SPI_M3 = 2'd3
  } spi_mode_e;

  // Modes with equal polarity and phase bits sample on the rising clock.
  function automatic logic samples_on_rise(input logic [1:0] m);
    return (m[1] == m[0]);
  endfunction
endpackage

// File: rtl/pm_cfg_regs.sv
`timescale 1ns/1ps
module pm_cfg_regs
  import pm_pkg::*;
#(
  parameter int NBYTES = 4,
  parameter int ADDR_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [ADDR_W-1:0]        cfg_addr,
  input  logic [BYTE_W-1:0]        cfg_wdata,
  output logic [NBYTES*BYTE_W-1:0] pat,
  output logic [NBYTES*BYTE_W-1:0] msk,
  output logic [1:0]               spi_mode
);
  localparam int MODE_ADDR = 2 * NBYTES;

  logic [1:0] mode_q;

  for (genvar k = 0; k < NBYTES; k++) begin : g_byte
    localparam int LO = (NBYTES - 1 - k) * BYTE_W;
    logic [BYTE_W-1:0] pat_q;
    logic [BYTE_W-1:0] msk_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pat_q <= '0;
        msk_q <= '1;
      end else if (cfg_we) begin
        if (cfg_addr == ADDR_W'(k))          pat_q <= cfg_wdata;
        if (cfg_addr == ADDR_W'(NBYTES + k)) msk_q <= cfg_wdata;
      end
    end

    // Byte 0 occupies the top of the vector to line up with the oldest shifted byte.
    assign pat[LO +: BYTE_W] = pat_q;
    assign msk[LO +: BYTE_W] = msk_q;

    p_pat_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == ADDR_W'(k)) |=> (pat_q == $past(cfg_wdata)));
    p_msk_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == ADDR_W'(NBYTES + k)) |=> (msk_q == $past(cfg_wdata)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                       mode_q <= SPI_M0;
    else if (cfg_we && cfg_addr == ADDR_W'(MODE_ADDR)) mode_q <= cfg_wdata[1:0];
  end

  assign spi_mode = mode_q;

  p_mode_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == ADDR_W'(MODE_ADDR)) |=> (mode_q == $past(cfg_wdata[1:0])));
  p_high_addr_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr > ADDR_W'(MODE_ADDR)) |=> $stable(mode_q));
endmodule

// File: rtl/pm_bit_strobe.sv
`timescale 1ns/1ps
module pm_bit_strobe
  import pm_pkg::*;
#(
  parameter int I2C_FRAME = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       i2c_sel,
  input  logic [1:0] spi_mode,
  input  logic       sclk,
  input  logic       sdi,
  input  logic       cs_n,
  input  logic       scl,
  input  logic       sda,
  output logic       bit_stb,
  output logic       bit_val,
  output logic       clr
);
  localparam int CW      = $clog2(I2C_FRAME);
  localparam int ACK_IDX = I2C_FRAME - 1;

  logic          sclk_q, scl_q, sda_q;
  logic [CW-1:0] bcnt;
  logic          sclk_rise, sclk_fall, scl_rise, spi_edge, start_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      sclk_q <= sclk;
      scl_q  <= scl;
      sda_q  <= sda;
    end
  end

  always_comb begin
    sclk_rise  = sclk & ~sclk_q;
    sclk_fall  = ~sclk & sclk_q;
    scl_rise   = scl & ~scl_q;
    start_seen = i2c_sel & scl & scl_q & sda_q & ~sda;
    spi_edge   = samples_on_rise(spi_mode) ? sclk_rise : sclk_fall;
    if (i2c_sel) begin
      bit_stb = scl_rise && (bcnt != CW'(ACK_IDX));
      bit_val = sda;
    end else begin
      bit_stb = spi_edge & ~cs_n;
      bit_val = sdi;
    end
    clr = start_seen;
  end

  // Frame bit counter: positions 0..ACK_IDX, the last one being the acknowledge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      bcnt <= '0;
    else if (start_seen || !i2c_sel) bcnt <= '0;
    else if (scl_rise)               bcnt <= (bcnt == CW'(ACK_IDX)) ? '0 : bcnt + 1'b1;
  end

  p_start_excl_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({clr, bit_stb}));
  p_ack_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (i2c_sel && !clr && scl_rise && bcnt == CW'(ACK_IDX)) |=> (bcnt == '0));
  p_start_restarts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (bcnt == '0));
endmodule

// File: rtl/pm_shift_match.sv
`timescale 1ns/1ps
module pm_shift_match #(
  parameter int SH_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_stb,
  input  logic            bit_val,
  input  logic            clr,
  input  logic [SH_W-1:0] pat,
  input  logic [SH_W-1:0] msk,
  output logic            trig
);
  logic [SH_W-1:0] sh, sh_nxt;
  logic            match_now, match_nxt;

  always_comb begin
    sh_nxt    = {sh[SH_W-2:0], bit_val};
    match_now = &((sh ^ pat) | msk);
    match_nxt = &((sh_nxt ^ pat) | msk);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      trig <= 1'b0;
    end else begin
      trig <= bit_stb & ~clr & match_nxt & ~match_now;
      if (clr)          sh <= '0;
      else if (bit_stb) sh <= sh_nxt;
    end
  end

  p_trig_after_stb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> $past(bit_stb));
  p_shift_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_stb && !clr) |=> $stable(sh));
  p_shift_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && !clr) |=> (sh[0] == $past(bit_val)));
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (sh == '0));
endmodule

// File: rtl/pm_proto_match.sv
`timescale 1ns/1ps
module pm_proto_match
  import pm_pkg::*;
#(
  parameter int NBYTES    = 4,
  parameter int ADDR_W    = 4,
  parameter int I2C_FRAME = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic              i2c_sel,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              cs_n,
  input  logic              scl,
  input  logic              sda,
  output logic              trig
);
  localparam int SH_W = NBYTES * BYTE_W;

  logic [SH_W-1:0] pat, msk;
  logic [1:0]      spi_mode;
  logic            bit_stb, bit_val, clr;

  pm_cfg_regs #(.NBYTES(NBYTES), .ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pat(pat), .msk(msk), .spi_mode(spi_mode)
  );

  pm_bit_strobe #(.I2C_FRAME(I2C_FRAME)) u_stb (
    .clk(clk), .rst_n(rst_n), .i2c_sel(i2c_sel), .spi_mode(spi_mode),
    .sclk(sclk), .sdi(sdi), .cs_n(cs_n), .scl(scl), .sda(sda),
    .bit_stb(bit_stb), .bit_val(bit_val), .clr(clr)
  );

  pm_shift_match #(.SH_W(SH_W)) u_match (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_val(bit_val), .clr(clr),
    .pat(pat), .msk(msk), .trig(trig)
  );

  p_trig_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !$past(cfg_we)) |=> !trig);
  p_cs_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!i2c_sel && cs_n && !$past(cfg_we)) |=> !trig);
endmodule

// File: tb/sim_pm_proto_match.sv
`timescale 1ns/1ps
module sim_pm_proto_match;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       i2c_sel = 1'b0;
  logic       sclk = 1'b0, sdi = 1'b0, cs_n = 1'b1, scl = 1'b1, sda = 1'b1;
  logic       trig;

  pm_proto_match u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .i2c_sel(i2c_sel), .sclk(sclk), .sdi(sdi),
    .cs_n(cs_n), .scl(scl), .sda(sda), .trig(trig)
  );

  always #2.5 clk = ~clk;

  int          vectors = 0;
  int          fails = 0;
  bit          done = 0;
  logic        exp_trig = 1'b0;
  string       cur_req = "R1 reset";
  logic [7:0]  bw [4];
  logic [7:0]  bm [4];
  logic [1:0]  bmode;
  logic [31:0] bsh;
  int          bcnt;
  logic [7:0]  lfsr = 8'h5D;

  function automatic bit mdl_match(input logic [31:0] s);
    for (int k = 0; k < 4; k++) begin
      logic [7:0] b;
      b = s[(3 - k) * 8 +: 8];
      if (((b ^ bw[k]) | bm[k]) != 8'hFF) return 1'b0;
    end
    return 1'b1;
  endfunction

  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      if (trig !== exp_trig) begin
        fails++;
        $display("FAIL %s: trig=%0b expected=%0b at %0t", cur_req, trig, exp_trig, $time);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic next_rand(output logic [7:0] v);
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    v = lfsr;
  endtask

  // Called right after the sampling edge is driven.
  task automatic sampled(input logic b);
    bit prev, t;
    prev = mdl_match(bsh);
    bsh  = {bsh[30:0], b};
    t    = mdl_match(bsh) && !prev;
    tick();
    exp_trig = t;
    tick();
    exp_trig = 1'b0;
  endtask

  task automatic cfg_write(input logic [3:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_we = 1'b0;
    if (a < 4)       bw[a] = d;
    else if (a < 8)  bm[a - 4] = d;
    else if (a == 8) bmode = d[1:0];
  endtask

  task automatic set_pattern(input logic [31:0] w, input logic [31:0] m);
    for (int k = 0; k < 4; k++) begin
      cfg_write(4'(k), w[(3 - k) * 8 +: 8]);
      cfg_write(4'(4 + k), m[(3 - k) * 8 +: 8]);
    end
  endtask

  task automatic set_mode(input logic [7:0] v);
    cs_n = 1'b1;
    tick();
    cfg_write(4'd8, v);
    sclk = bmode[1];
    tick(); tick();
    cs_n = 1'b0;
    tick();
  endtask

  task automatic spi_bit(input logic b);
    sdi = b;
    tick();
    sclk = ~bmode[1];
    if (!bmode[0] && !cs_n) sampled(b); else begin tick(); tick(); end
    sclk = bmode[1];
    if (bmode[0] && !cs_n) sampled(b); else begin tick(); tick(); end
  endtask

  task automatic spi_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) spi_bit(v[i]);
  endtask

  task automatic i2c_rise(input logic b);
    scl = 1'b1;
    if (bcnt == 8) begin bcnt = 0; tick(); tick(); end
    else begin bcnt++; sampled(b); end
  endtask

  task automatic i2c_clk(input logic b);
    sda = b;
    tick();
    i2c_rise(b);
    scl = 1'b0;
    tick();
  endtask

  task automatic i2c_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) i2c_clk(v[i]);
    i2c_clk(1'b0);
  endtask

  task automatic i2c_start();
    sda = 1'b1;
    tick();
    if (!scl) i2c_rise(1'b1);
    sda = 1'b0;
    tick();
    bsh = '0; bcnt = 0;
    tick();
    scl = 1'b0;
    tick();
  endtask

  initial begin
    for (int k = 0; k < 4; k++) begin bw[k] = 8'h00; bm[k] = 8'hFF; end
    bmode = 2'd0; bsh = '0; bcnt = 0;

    cur_req = "R1 reset state";
    repeat (4) tick();
    rst_n = 1'b1;
    tick();

    // R1: only byte 3 programmed; bytes 0..2 rely on their reset masks.
    cur_req = "R1 reset masks";
    set_mode(8'h00);
    cfg_write(4'd3, 8'hA5);
    cfg_write(4'd7, 8'h00);
    spi_byte(8'h3C);
    spi_byte(8'hA5);

    // R3: byte order in the four slots.
    cur_req = "R3 byte order";
    set_pattern(32'h12345678, 32'h0);
    spi_byte(8'h00);
    spi_byte(8'h12); spi_byte(8'h34); spi_byte(8'h56); spi_byte(8'h78);
    spi_byte(8'h78); spi_byte(8'h56); spi_byte(8'h34); spi_byte(8'h12);
    spi_byte(8'h12); spi_byte(8'h34); spi_byte(8'h56); spi_byte(8'h78);

    // R5: a match that stays true raises no second pulse.
    cur_req = "R5 already matching";
    set_pattern(32'h00000001, 32'hFFFFFFFE);
    spi_bit(1'b0); spi_bit(1'b1); spi_bit(1'b1); spi_bit(1'b1); spi_bit(1'b0); spi_bit(1'b1);
    cur_req = "R5 all ignored";
    set_pattern(32'h0, 32'hFFFFFFFF);
    spi_byte(8'hC3); spi_byte(8'h00);

    // R4/R6: sweep all SPI modes and several mask shapes.
    for (int m = 0; m < 4; m++) begin
      for (int v = 0; v < 3; v++) begin
        logic [31:0] w, mk;
        logic [7:0]  r;
        for (int k = 0; k < 4; k++) begin next_rand(r); w[k * 8 +: 8] = r; end
        mk = (v == 0) ? 32'h0 : (v == 1) ? 32'h0F00F0FF : 32'hFFFF0081;
        cur_req = (v == 0) ? "R6 mode sweep, full mask" : "R4 mask sweep";
        set_mode(8'(m));
        set_pattern(w, mk);
        for (int n = 0; n < 6; n++) begin next_rand(r); spi_byte(r); end
        for (int k = 3; k >= 0; k--) spi_byte(w[k * 8 +: 8]);
        next_rand(r); spi_byte(r);
      end
    end

    // R7: clock edges with chip select high leave the register untouched.
    cur_req = "R7 chip select high";
    set_mode(8'h00);
    set_pattern(32'h00A1B2C3, 32'hFF000000);
    spi_byte(8'hA1);
    cs_n = 1'b1;
    spi_byte(8'hB2); spi_byte(8'hC3);
    cs_n = 1'b0;
    tick();
    spi_byte(8'hB2); spi_byte(8'hC3);

    // R2: writes above the mode address change nothing; mode takes only bits 1:0.
    cur_req = "R2 unused addresses";
    set_pattern(32'h0000F00D, 32'hFFFF0000);
    for (int a = 9; a < 16; a++) begin
      cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 8'h00;
      tick();
      cfg_we = 1'b0;
    end
    cur_req = "R2 mode field";
    set_mode(8'hFD);
    spi_byte(8'h11); spi_byte(8'hF0); spi_byte(8'h0D);

    // R10: short two-byte pattern in the high slots.
    cur_req = "R10 short pattern";
    set_mode(8'h03);
    set_pattern(32'h0000C33C, 32'hFFFF0000);
    spi_byte(8'hC3); spi_byte(8'h3C);

    // R8: I2C bytes with acknowledge clocks.
    cs_n = 1'b1; scl = 1'b1; sda = 1'b1;
    tick();
    i2c_sel = 1'b1; bcnt = 0;
    tick(); tick();
    cur_req = "R8 i2c ack skipped";
    set_pattern(32'h0000A05A, 32'hFFFF0000);
    i2c_start();
    i2c_byte(8'hA0); i2c_byte(8'h5A);

    // R9: repeated start clears the previous content.
    cur_req = "R9 start clears";
    set_pattern(32'h0000005A, 32'hFFFF0000);
    i2c_byte(8'hFF);
    i2c_start();
    i2c_byte(8'h5A);
    i2c_byte(8'h5A);

    repeat (3) tick();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #750000;
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule